// File: doc/BRIEF.md
# Decoder Status and Soft-Reset Controller

This block is the register front end of a bitstream decoder. It sits on a simple host register bus and holds the decoder's sticky status flags. These are a bitstream-error flag and a start-code flag. It drives a level interrupt toward the host and turns host command writes into a flush pulse or a deferred soft reset. It also shows the live 16-bit decoder shift register through a read-only shadow word. Finally, it keeps the quantizer scale, taken from the slice header, that is presented to the datapath until a macroblock-level code replaces it.

A soft reset is never applied mid-transaction. When the host writes the reset command, the block stops granting new memory-bus transactions and raises a busy bit. It then counts outstanding transactions down as they complete. In the cycle after the count reaches zero, it issues one full clear of every register and a buffer-empty pulse. The hardware reset input clears the same state at once, with no wait.

Top module: `dec_ctrl_regs`

## Requirements
- R1: A cycle with `err_i` high sets the error flag, status word (address 0) bit 0. A set in the same cycle as a host clear of that bit wins.
- R2: A cycle with `err_i` and `sc_present_i` both high sets the error flag (status bit 0) and the start-code flag (status bit 1) together.
- R3: A host write to address 0 clears each flag whose data bit is 1 and leaves a flag whose data bit is 0 unchanged.
- R4: `irq_o` is high exactly while the error flag is set and the interrupt enable (address 1, bit 0) is 1.
- R5: Address 2 is a command word. Bit 0 requests reset and bit 1 requests flush. It reads as 0. A flush write gives a single-cycle `flush_o` in the next cycle. An error alone never drives `flush_o`.
- R6: After a reset command, status bit 2 (busy) reads 1 and `txn_start_o` stays low. Completions of transactions that were already started are still counted.
- R7: In the cycle after the outstanding count reaches zero while busy, `soft_rst_o` and `flush_o` are high for one cycle. At the following edge, every status and control register and the busy bit are zero. With nothing outstanding, this cycle is the one right after the command write.
- R8: A low `rst_ni` clears all state immediately, including a drain that is in progress.
- R9: Address 3 returns `shreg_i` in bits 15:0 and zero in bits 31:16. Writes to it have no effect.
- R10: `qscale_o` shows the slice-level scale, which is loaded by `slice_qs_ld_i` or by a host write to address 4 (bits 4:0). A `mb_qs_vld_i` overrides it until the next slice load or host write. Address 4 reads back the slice-level value.
- R11: `txn_start_o` follows `txn_req_i` while not busy and while fewer than MAX_OUT (4) transactions are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 3 | Host word address for read and write |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| err_i | input | 1 | Bitstream error event from the datapath |
| sc_present_i | input | 1 | Start code currently held in the shift register |
| shreg_i | input | 16 | Live decoder shift register |
| slice_qs_ld_i | input | 1 | Load slice-level quantizer scale |
| slice_qs_i | input | 5 | Slice-level quantizer scale |
| mb_qs_vld_i | input | 1 | Macroblock-level scale override valid |
| mb_qs_i | input | 5 | Macroblock-level quantizer scale |
| qscale_o | output | 5 | Quantizer scale in effect |
| txn_req_i | input | 1 | Datapath asks to start a bus transaction |
| txn_start_o | output | 1 | Transaction start granted this cycle |
| txn_done_i | input | 1 | One outstanding transaction completed |
| irq_o | output | 1 | Level interrupt to the host |
| flush_o | output | 1 | Empty the output buffers (one-cycle pulse) |
| soft_rst_o | output | 1 | Full soft reset of the datapath (one-cycle pulse) |

## Verification
The embedded assertions check several rules on every cycle. An error event always lands in the flag. A lone clear empties the flag. The outstanding count never exceeds its bound. Busy holds while transactions are pending, and the last completion is followed by exactly one reset pulse, which returns the sequencer to idle. An error without a command never flushes, and the quantizer scale stays stable when nothing loads it.

Some rules only the bench's scenarios can show. These are that every register really reads zero after the deferred reset and that a hardware reset aborts a drain. They also include the saturation of grants at the outstanding limit, the override-then-revert order of the quantizer scale, and that writes to the shadow word are ignored. The bench shows these by comparing a behavioural model against the ports on every clock.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] A_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL   = 3'd1;
  localparam logic [REG_AW-1:0] A_CMD    = 3'd2;
  localparam logic [REG_AW-1:0] A_SHADOW = 3'd3;
  localparam logic [REG_AW-1:0] A_QSCALE = 3'd4;

  localparam int unsigned NFLAG     = 2;
  localparam int unsigned ST_ERR    = 0;
  localparam int unsigned ST_SC     = 1;
  localparam int unsigned ST_BUSY   = 2;
  localparam int unsigned CMD_RST   = 0;
  localparam int unsigned CMD_FLUSH = 1;
  localparam int unsigned CTL_IRQEN = 0;

  typedef enum logic {SEQ_RUN, SEQ_DRAIN} seq_e;
endpackage

// File: rtl/dcr_status.sv
module dcr_status
  import dcr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] w1c_i,
  input  logic             en_we_i,
  input  logic             en_d_i,
  output logic [NFLAG-1:0] flag_o,
  output logic             irq_en_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else if (clr_all_i) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NFLAG; i++) begin
        if (set_i[i])      flag_q[i] <= 1'b1;   // set beats clear
        else if (w1c_i[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (clr_all_i) en_q <= 1'b0;
    else if (en_we_i)   en_q <= en_d_i;
  end

  assign flag_o   = flag_q;
  assign irq_en_o = en_q;
  assign irq_o    = flag_q[ST_ERR] & en_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag_chk
    // R1
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] && !clr_all_i |=> flag_o[g]);
    // R3
    flag_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w1c_i[g] && !set_i[g] |=> !flag_o[g]);
  end
endmodule

// File: rtl/dcr_drain.sv
module dcr_drain
  import dcr_pkg::*;
#(
  parameter int unsigned MAX_OUT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_cmd_i,
  input  logic txn_req_i,
  input  logic txn_done_i,
  output logic txn_start_o,
  output logic busy_o,
  output logic soft_rst_o
);
  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  seq_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign busy_o      = (st_q == SEQ_DRAIN);
  assign soft_rst_o  = busy_o && (cnt_q == '0);
  assign txn_start_o = txn_req_i && !busy_o && (cnt_q < CNT_MAX);
  assign dec         = txn_done_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_RUN;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(txn_start_o) - CNT_W'(dec);
      if (soft_rst_o)     st_q <= SEQ_RUN;
      else if (rst_cmd_i) st_q <= SEQ_DRAIN;
    end
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  // R6
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q != '0 |=> busy_o && !txn_start_o);
  // R7
  last_done_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_q == CNT_W'(1) && txn_done_i |=> soft_rst_o);
  // R7
  rst_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !busy_o && cnt_q == '0);
endmodule

// File: rtl/dcr_qscale.sv
module dcr_qscale #(
  parameter int unsigned QS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            slice_ld_i,
  input  logic [QS_W-1:0] slice_qs_i,
  input  logic            mb_vld_i,
  input  logic [QS_W-1:0] mb_qs_i,
  input  logic            host_we_i,
  input  logic [QS_W-1:0] host_qs_i,
  output logic [QS_W-1:0] qs_reg_o,
  output logic [QS_W-1:0] qscale_o
);
  logic [QS_W-1:0] qs_q, mb_q;
  logic            ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qs_q <= '0; mb_q <= '0; ovr_q <= 1'b0;
    end else if (clr_i) begin
      qs_q <= '0; mb_q <= '0; ovr_q <= 1'b0;
    end else if (mb_vld_i) begin
      mb_q <= mb_qs_i; ovr_q <= 1'b1;
    end else if (slice_ld_i) begin
      qs_q <= slice_qs_i; ovr_q <= 1'b0;
    end else if (host_we_i) begin
      qs_q <= host_qs_i; ovr_q <= 1'b0;
    end
  end

  assign qs_reg_o = qs_q;
  assign qscale_o = ovr_q ? mb_q : qs_q;

  // R10
  qs_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slice_ld_i && !mb_vld_i && !clr_i |=> qscale_o == $past(slice_qs_i));
  // R10
  qs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slice_ld_i && !mb_vld_i && !host_we_i && !clr_i |=> $stable(qscale_o));
endmodule

// File: rtl/dec_ctrl_regs.sv
module dec_ctrl_regs
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SR_W    = 16,
  parameter int unsigned QS_W    = 5,
  parameter int unsigned MAX_OUT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              err_i,
  input  logic              sc_present_i,
  input  logic [SR_W-1:0]   shreg_i,
  input  logic              slice_qs_ld_i,
  input  logic [QS_W-1:0]   slice_qs_i,
  input  logic              mb_qs_vld_i,
  input  logic [QS_W-1:0]   mb_qs_i,
  output logic [QS_W-1:0]   qscale_o,
  input  logic              txn_req_i,
  output logic              txn_start_o,
  input  logic              txn_done_i,
  output logic              irq_o,
  output logic              flush_o,
  output logic              soft_rst_o
);
  logic             wr_status, wr_ctrl, wr_cmd, wr_qs;
  logic             rst_cmd, flush_cmd, flush_q, busy, irq_en;
  logic [NFLAG-1:0] flag_set, flag_w1c, flags;
  logic [QS_W-1:0]  qs_reg;

  assign wr_status = reg_we_i && (reg_addr_i == A_STATUS);
  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_cmd    = reg_we_i && (reg_addr_i == A_CMD);
  assign wr_qs     = reg_we_i && (reg_addr_i == A_QSCALE);
  assign rst_cmd   = wr_cmd && reg_wdata_i[CMD_RST];
  assign flush_cmd = wr_cmd && reg_wdata_i[CMD_FLUSH];

  always_comb begin
    flag_set         = '0;
    flag_set[ST_ERR] = err_i;
    flag_set[ST_SC]  = err_i && sc_present_i;
  end
  assign flag_w1c = wr_status ? reg_wdata_i[NFLAG-1:0] : '0;

  dcr_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (soft_rst_o),
    .set_i     (flag_set),
    .w1c_i     (flag_w1c),
    .en_we_i   (wr_ctrl),
    .en_d_i    (reg_wdata_i[CTL_IRQEN]),
    .flag_o    (flags),
    .irq_en_o  (irq_en),
    .irq_o     (irq_o)
  );

  dcr_drain #(.MAX_OUT(MAX_OUT)) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_cmd_i   (rst_cmd),
    .txn_req_i   (txn_req_i),
    .txn_done_i  (txn_done_i),
    .txn_start_o (txn_start_o),
    .busy_o      (busy),
    .soft_rst_o  (soft_rst_o)
  );

  dcr_qscale #(.QS_W(QS_W)) u_qscale (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst_o),
    .slice_ld_i (slice_qs_ld_i),
    .slice_qs_i (slice_qs_i),
    .mb_vld_i   (mb_qs_vld_i),
    .mb_qs_i    (mb_qs_i),
    .host_we_i  (wr_qs),
    .host_qs_i  (reg_wdata_i[QS_W-1:0]),
    .qs_reg_o   (qs_reg),
    .qscale_o   (qscale_o)
  );

  // command bits self-clear: only a one-cycle pulse is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flush_q <= 1'b0;
    else if (soft_rst_o) flush_q <= 1'b0;
    else                 flush_q <= flush_cmd;
  end
  assign flush_o = flush_q | soft_rst_o;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_STATUS: begin
        reg_rdata_o[NFLAG-1:0] = flags;
        reg_rdata_o[ST_BUSY]   = busy;
      end
      A_CTRL:   reg_rdata_o[CTL_IRQEN] = irq_en;
      A_SHADOW: reg_rdata_o[SR_W-1:0]  = shreg_i;
      A_QSCALE: reg_rdata_o[QS_W-1:0]  = qs_reg;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R2
  err_sc_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && sc_present_i && !soft_rst_o |=> flags[ST_ERR] && flags[ST_SC]);
  // R5
  err_no_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !wr_cmd && !busy |=> !flush_o);
  // R4
  irq_needs_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags[ST_ERR]);
endmodule

// File: tb/dec_ctrl_regs_tb.sv
module dec_ctrl_regs_tb;
  localparam int MAXO = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic        err = 1'b0, scp = 1'b0;
  logic [15:0] shreg = 16'h0;
  logic        slice_ld = 1'b0, mb_vld = 1'b0;
  logic [4:0]  slice_qs = '0, mb_qs = '0, qscale;
  logic        txn_req = 1'b0, txn_start, txn_done = 1'b0;
  logic        irq, flush, srst;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dec_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .err_i(err),
    .sc_present_i(scp), .shreg_i(shreg), .slice_qs_ld_i(slice_ld),
    .slice_qs_i(slice_qs), .mb_qs_vld_i(mb_vld), .mb_qs_i(mb_qs),
    .qscale_o(qscale), .txn_req_i(txn_req), .txn_start_o(txn_start),
    .txn_done_i(txn_done), .irq_o(irq), .flush_o(flush), .soft_rst_o(srst)
  );

  // behavioural reference model
  bit m_err, m_sc, m_en, m_ovr, m_drain, m_fl;
  int m_qs, m_mbqs, m_out;
  bit sr, st, dn, wst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = 0; m_sc = 0; m_en = 0; m_ovr = 0; m_drain = 0; m_fl = 0;
      m_qs = 0; m_mbqs = 0; m_out = 0;
    end else begin
      sr  = m_drain && m_out == 0;
      st  = txn_req && !m_drain && m_out < MAXO;
      dn  = txn_done && m_out > 0;
      wst = reg_we && reg_addr == 3'd0;
      if (sr) begin
        m_err = 0; m_sc = 0; m_en = 0; m_ovr = 0; m_drain = 0; m_fl = 0;
        m_qs = 0; m_mbqs = 0;
      end else begin
        m_out = m_out + (st ? 1 : 0) - (dn ? 1 : 0);
        if (err) m_err = 1; else if (wst && reg_wdata[0]) m_err = 0;
        if (err && scp) m_sc = 1; else if (wst && reg_wdata[1]) m_sc = 0;
        if (reg_we && reg_addr == 3'd1) m_en = reg_wdata[0];
        if (reg_we && reg_addr == 3'd2 && reg_wdata[0]) m_drain = 1;
        m_fl = reg_we && reg_addr == 3'd2 && reg_wdata[1];
        if (mb_vld) begin m_mbqs = mb_qs; m_ovr = 1; end
        else if (slice_ld) begin m_qs = slice_qs; m_ovr = 0; end
        else if (reg_we && reg_addr == 3'd4) begin m_qs = reg_wdata[4:0]; m_ovr = 0; end
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (reg_addr)
      3'd0: return {29'b0, m_drain, m_sc, m_err};
      3'd1: return {31'b0, m_en};
      3'd3: return {16'b0, shreg};
      3'd4: return 32'(m_qs);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string addr_tag();
    case (reg_addr)
      3'd0: return "R1/R2/R3/R6 status";
      3'd1: return "R4 ctrl";
      3'd2: return "R5 cmd";
      3'd3: return "R9 shadow";
      3'd4: return "R10 qscale reg";
      default: return "R9 unmapped";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      chk(addr_tag(), rdata, exp_rdata());
      chk("R4 irq_o", 32'(irq), 32'(m_err && m_en));
      chk("R11 txn_start_o", 32'(txn_start), 32'(txn_req && !m_drain && m_out < MAXO));
      chk("R7 soft_rst_o", 32'(srst), 32'(m_drain && m_out == 0));
      chk("R5 flush_o", 32'(flush), 32'(m_fl || (m_drain && m_out == 0)));
      chk("R10 qscale_o", 32'(qscale), 32'(m_ovr ? m_mbqs : m_qs));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic pulse_err(bit sc);
    @(negedge clk); err = 1; scp = sc;
    @(negedge clk); err = 0; scp = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); txn_done = 1;
    @(negedge clk); txn_done = 0;
  endtask

  task automatic look(logic [2:0] a);
    @(negedge clk); reg_addr = a; #3;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); #3;
    chk("R8 reset status", rdata, 32'h0);
    @(negedge clk); rst_n = 1;
    cyc(2);

    // R1 / R4: error with interrupt enabled
    wr(3'd1, 32'h1);
    pulse_err(0);
    look(3'd0);
    chk("R1 err flag", rdata, 32'h1);
    chk("R4 irq high", 32'(irq), 32'h1);
    chk("R5 no flush on error", 32'(flush), 32'h0);
    // R3: write 0 leaves it, write 1 clears
    wr(3'd0, 32'h0); #3;
    chk("R3 w1c zero keeps", rdata, 32'h1);
    wr(3'd0, 32'h1); #3;
    chk("R3 w1c one clears", rdata, 32'h0);
    chk("R4 irq low", 32'(irq), 32'h0);
    // R2: error with start code
    pulse_err(1); #3;
    chk("R2 both flags", rdata, 32'h3);
    wr(3'd0, 32'h2); #3;
    chk("R3 clear sc only", rdata, 32'h1);
    // R1: set wins over simultaneous clear
    @(negedge clk); reg_we = 1; reg_addr = 3'd0; reg_wdata = 32'h1; err = 1;
    @(negedge clk); reg_we = 0; err = 0; #3;
    chk("R1 set beats clear", rdata, 32'h1);
    wr(3'd1, 32'h0); #3;
    chk("R4 irq off when disabled", 32'(irq), 32'h0);
    wr(3'd1, 32'h1);

    // R5: flush command
    wr(3'd2, 32'h2); #3;
    chk("R5 flush pulse", 32'(flush), 32'h1);
    cyc(1); #3;
    chk("R5 flush one cycle", 32'(flush), 32'h0);
    look(3'd2);
    chk("R5 cmd reads zero", rdata, 32'h0);

    // R9: shadow
    look(3'd3);
    shreg = 16'hA5C3; #1;
    chk("R9 shadow live", rdata, 32'h0000A5C3);
    wr(3'd3, 32'hFFFF_FFFF); #3;
    chk("R9 shadow write ignored", rdata, 32'h0000A5C3);
    shreg = 16'h1234; cyc(1);

    // R10: quantizer scale
    @(negedge clk); slice_ld = 1; slice_qs = 5'd9;
    @(negedge clk); slice_ld = 0; #3;
    chk("R10 slice value out", 32'(qscale), 32'd9);
    @(negedge clk); mb_vld = 1; mb_qs = 5'd21;
    @(negedge clk); mb_vld = 0; #3;
    chk("R10 mb override", 32'(qscale), 32'd21);
    look(3'd4);
    chk("R10 reg keeps slice", rdata, 32'd9);
    cyc(3);
    chk("R10 override held", 32'(qscale), 32'd21);
    wr(3'd4, 32'd14); #3;
    chk("R10 host write reverts", 32'(qscale), 32'd14);

    // R11 / R6 / R7: transactions then deferred reset
    @(negedge clk); txn_req = 1;
    cyc(3); txn_req = 0; #3;
    pulse_err(0);
    wr(3'd2, 32'h1);
    look(3'd0);
    chk("R6 busy bit", rdata & 32'h4, 32'h4);
    chk("R7 no reset while pending", 32'(srst), 32'h0);
    txn_req = 1; #1;
    chk("R6 no start in drain", 32'(txn_start), 32'h0);
    cyc(1); txn_req = 0;
    done_pulse();
    done_pulse();
    #3; chk("R7 still pending", 32'(srst), 32'h0);
    done_pulse(); #3;
    chk("R7 reset after last done", 32'(srst), 32'h1);
    chk("R7 buffers flushed", 32'(flush), 32'h1);
    cyc(1); #3;
    chk("R7 status cleared", rdata, 32'h0);
    chk("R7 irq cleared", 32'(irq), 32'h0);
    chk("R7 qscale cleared", 32'(qscale), 32'h0);
    look(3'd1);
    chk("R7 ctrl cleared", rdata, 32'h0);

    // R7: nothing outstanding
    wr(3'd2, 32'h1); #3;
    chk("R7 immediate reset", 32'(srst), 32'h1);
    cyc(1); #3;
    chk("R7 single pulse", 32'(srst), 32'h0);

    // R11: saturation at the outstanding limit
    @(negedge clk); txn_req = 1;
    cyc(5); #3;
    chk("R11 grant stops at limit", 32'(txn_start), 32'h0);
    done_pulse(); #3;
    chk("R11 grant resumes", 32'(txn_start), 32'h1);
    cyc(1); txn_req = 0;

    // R8: hardware reset aborts a drain
    wr(3'd1, 32'h1);
    pulse_err(1);
    wr(3'd2, 32'h1);
    look(3'd0);
    chk("R6 busy before hw reset", rdata, 32'h7);
    @(negedge clk); rst_n = 0; #3;
    chk("R8 hw reset clears", rdata, 32'h0);
    chk("R8 hw reset irq", 32'(irq), 32'h0);
    cyc(2); rst_n = 1;
    cyc(3); #3;
    chk("R8 idle after hw reset", rdata, 32'h0);

    cyc(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule